// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Sequencer

This block is the control-register slice that puts a peripheral into soft reset and stops its clock. One 8-bit control word holds a soft-reset request, a clock-gate status bit, an enable bit and a two-bit bus-width field. The word can be written in three ways: a plain write, an OR-in write and a clear-by-mask write. Each way has its own address, so software can change single bits without a read-modify-write.

When software sets the soft-reset bit, the functional reset output rises at once. The functional clock keeps running long enough for the reset to reach the functional logic. After a fixed number of cycles the hardware sets the clock-gate bit, and the functional clock enable drops. Software polls for the gate bit and then clears soft reset. The reset output stays high for a minimum hold time measured in clock cycles. The clock stays gated until software clears the gate bit itself.

Top module: `srst_gate_ctrl`

## Requirements
- R1: Address 0 writes the word as given, address 1 ORs the written ones into it, address 2 clears the bits written as one, and a write to address 3 changes nothing. Bits 5:3 are reserved and always read 0.
- R2: rdata shows the current control word at every address, including address 3.
- R3: The field layout is: bit 0 enable, bits 2:1 bus width, bit 6 clock gate, bit 7 soft reset. After hardware reset the word reads 0x00, func_rst is 0 and func_clk_en is 1.
- R4: If soft reset stays 1, the hardware sets the gate bit exactly GATE_DELAY cycles after the clock edge that wrote soft reset to 1. Before that cycle the gate bit remains 0.
- R5: func_rst is 1 in the cycle after soft reset is written to 1, and it stays 1 while the bit is 1.
- R6: While soft reset is 1, the enable bit and the bus-width field read 0 and writes to them have no effect. Once the soft-reset bit already reads 1, software writes to the gate bit have no effect.
- R7: After soft reset is cleared, func_rst stays 1 for CLK_MHZ*HOLD_NS/1000 cycles counted from the clearing edge, then falls to 0.
- R8: func_clk_en is the inverse of the gate bit. After soft reset is released the gate bit stays 1 until software clears it, and clearing it brings func_clk_en back to 1.
- R9: If soft reset is cleared before GATE_DELAY cycles have passed, the gate bit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 2 | Write mode: 0 plain, 1 set, 2 clear, 3 none |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current control word |
| func_rst | output | 1 | Reset to the functional logic |
| func_clk_en | output | 1 | Clock enable to the functional logic |

## Verification
Every output comes straight from a register. A write becomes visible on rdata, func_rst and func_clk_en in the cycle after its edge, and the bench samples these outputs on the falling edge after that write edge. The gate bit is due GATE_DELAY edges after the write that sets soft reset, so the bench checks it on each falling edge across that window. The reset hold is due to end CLK_MHZ*HOLD_NS/1000 edges after the releasing write; the bench counts those edges itself and expects func_rst high on every one except the last.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 0;
  localparam int BW_LSB   = 1;
  localparam int BW_W     = 2;
  localparam int GATE_BIT = 6;
  localparam int SRST_BIT = 7;
  localparam logic [REG_W-1:0] LIVE_MASK = 8'hC7;
  localparam logic [REG_W-1:0] CFG_MASK  = 8'h07;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,
    WR_SET   = 2'd1,
    WR_CLR   = 2'd2,
    WR_NONE  = 2'd3
  } wr_mode_e;

  // Applies one bus write to the current word.
  function automatic logic [REG_W-1:0] merge_write(
      input logic [REG_W-1:0] cur, input logic [1:0] mode,
      input logic [REG_W-1:0] data);
    logic [REG_W-1:0] res;
    case (wr_mode_e'(mode))
      WR_PLAIN: res = data;
      WR_SET:   res = cur | data;
      WR_CLR:   res = cur & ~data;
      default:  res = cur;
    endcase
    return res & LIVE_MASK;
  endfunction

  // Converts a hold time in ns to whole clock cycles, with a minimum of one.
  function automatic int hold_cycles(input int clk_mhz, input int hold_ns);
    int c;
    c = (clk_mhz * hold_ns) / 1000;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sgc_alias_write.sv
module sgc_alias_write
  import sgc_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] nxt
);
  always_comb begin
    nxt = cur & LIVE_MASK;
    if (wr_en) nxt = merge_write(cur, addr, wdata);
  end
endmodule

// File: rtl/sgc_gate_timer.sv
module sgc_gate_timer #(
  parameter int GATE_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_q,
  output logic gate_hit
);
  localparam int CW = (GATE_DELAY > 1) ? $clog2(GATE_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(GATE_DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!srst_q)        cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign gate_hit = srst_q && (cnt_q == LAST);
endmodule

// File: rtl/sgc_release_hold.sv
module sgc_release_hold #(
  parameter int HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_q,
  output logic hold_active
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (srst_q)      cnt_q <= CW'(HOLD_CYC);
    else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_active = (cnt_q != 0);
endmodule

// File: rtl/srst_gate_ctrl.sv
module srst_gate_ctrl
  import sgc_pkg::*;
#(
  parameter int GATE_DELAY = 4,
  parameter int CLK_MHZ    = 50,
  parameter int HOLD_NS    = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             func_rst,
  output logic             func_clk_en
);
  localparam int HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] bus_nxt;
  logic [REG_W-1:0] ctrl_d;
  logic             srst_q;
  logic             gate_q;
  logic             gate_hit;
  logic             hold_active;

  assign srst_q = ctrl_q[SRST_BIT];
  assign gate_q = ctrl_q[GATE_BIT];

  sgc_alias_write u_alias (
    .cur(ctrl_q), .wr_en(wr_en), .addr(addr), .wdata(wdata), .nxt(bus_nxt)
  );

  sgc_gate_timer #(.GATE_DELAY(GATE_DELAY)) u_gate (
    .clk(clk), .rst_n(rst_n), .srst_q(srst_q), .gate_hit(gate_hit)
  );

  sgc_release_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .srst_q(srst_q), .hold_active(hold_active)
  );

  always_comb begin
    ctrl_d = bus_nxt;
    if (ctrl_d[SRST_BIT]) begin
      ctrl_d[EN_BIT] = 1'b0;
      ctrl_d[BW_LSB +: BW_W] = '0;
    end
    if (srst_q) ctrl_d[GATE_BIT] = gate_q | gate_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign rdata       = ctrl_q;
  assign func_rst    = srst_q | hold_active;
  assign func_clk_en = ~gate_q;
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker
  import sgc_pkg::*;
#(
  parameter int GATE_DELAY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             func_rst,
  input logic             func_clk_en,
  input logic             gate_hit
);
  localparam int CW = $clog2(GATE_DELAY + 1) + 1;
  logic [CW-1:0] in_rst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              in_rst_cnt <= '0;
    else if (!rdata[SRST_BIT])               in_rst_cnt <= '0;
    else if (in_rst_cnt != CW'(GATE_DELAY))  in_rst_cnt <= in_rst_cnt + 1'b1;
  end

  a_r1_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !rdata[SRST_BIT] && !wdata[SRST_BIT])
      |=> ((rdata & $past(wdata) & CFG_MASK) == ($past(wdata) & CFG_MASK)));

  a_r1_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && wdata[EN_BIT]) |=> !rdata[EN_BIT]);

  a_r4_gate_timing: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdata[GATE_BIT]) && $past(rdata[SRST_BIT])) |-> (in_rst_cnt == CW'(GATE_DELAY)));

  a_r4_hit_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hit |-> rdata[SRST_BIT]);

  a_r5_rst_follows_srst: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[SRST_BIT] |-> func_rst);

  a_r6_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[SRST_BIT] |-> (rdata[EN_BIT] == 1'b0 && rdata[BW_LSB +: BW_W] == '0));

  a_r6_gate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[SRST_BIT] && rdata[GATE_BIT]) |=> rdata[GATE_BIT]);

  a_r7_hold_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[SRST_BIT]) |-> func_rst);

  a_r8_clock_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(func_clk_en) |-> ($past(rdata[SRST_BIT]) || $past(wr_en)));
endmodule

bind srst_gate_ctrl sgc_checker #(.GATE_DELAY(GATE_DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .func_rst(func_rst), .func_clk_en(func_clk_en),
  .gate_hit(gate_hit)
);

// File: tb/srst_gate_ctrl_tb.sv
module srst_gate_ctrl_tb_top;
  localparam int PERIOD = 10;
  localparam int GDLY   = 4;
  localparam int MHZ    = 50;
  localparam int HNS    = 1000;
  localparam int HOLD   = MHZ * HNS / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       func_rst, func_clk_en;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  srst_gate_ctrl #(.GATE_DELAY(GDLY), .CLK_MHZ(MHZ), .HOLD_NS(HNS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .func_rst(func_rst), .func_clk_en(func_clk_en)
  );

  // {addr, wdata, expected word, expected clock enable}
  localparam logic [18:0] VEC [8] = '{
    {2'd0, 8'h3D, 8'h05, 1'b1},  // R1 plain, reserved bits dropped
    {2'd1, 8'h02, 8'h07, 1'b1},  // R1 set
    {2'd2, 8'h01, 8'h06, 1'b1},  // R1 clear
    {2'd3, 8'hFF, 8'h06, 1'b1},  // R1/R2 ignored write, read at addr 3
    {2'd1, 8'h40, 8'h46, 1'b0},  // R8 software gate
    {2'd2, 8'h40, 8'h06, 1'b1},  // R8 ungate
    {2'd0, 8'h00, 8'h00, 1'b1},  // R1 plain zero
    {2'd1, 8'h01, 8'h01, 1'b1}   // R1 set enable
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset word", rdata, 8'h00);
    check("R3 reset func_rst", func_rst, 1'b0);
    check("R3 reset clk_en", func_clk_en, 1'b1);

    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][18:17], VEC[i][16:9]);
      check("R1 R2 vector word", rdata, VEC[i][8:1]);
      check("R8 vector clk_en", func_clk_en, VEC[i][0]);
    end

    // Soft reset entry
    do_write(2'd0, 8'h07);
    do_write(2'd1, 8'h80);
    check("R6 cfg cleared on entry", rdata, 8'h80);
    check("R5 func_rst on entry", func_rst, 1'b1);
    for (int k = 1; k <= GDLY; k++) begin
      @(negedge clk);
      check("R4 gate timing", rdata[6], (k >= GDLY) ? 1'b1 : 1'b0);
    end
    check("R8 clock stopped", func_clk_en, 1'b0);

    do_write(2'd0, 8'h83);
    check("R6 cfg write ignored in reset", rdata, 8'hC0);
    do_write(2'd2, 8'h40);
    check("R6 gate clear ignored in reset", rdata, 8'hC0);
    check("R5 func_rst held", func_rst, 1'b1);

    // Release
    do_write(2'd2, 8'h80);
    check("R7 word after release", rdata, 8'h40);
    check("R7 func_rst right after release", func_rst, 1'b1);
    begin
      int miss = 0;
      for (int k = 1; k <= HOLD; k++) begin
        @(negedge clk);
        if (func_rst !== ((k < HOLD) ? 1'b1 : 1'b0)) miss++;
      end
      check("R7 hold window mismatches", miss, 0);
    end
    check("R7 func_rst low after hold", func_rst, 1'b0);
    check("R8 still gated after release", func_clk_en, 1'b0);
    do_write(2'd2, 8'h40);
    check("R8 ungate word", rdata, 8'h00);
    check("R8 ungate clk_en", func_clk_en, 1'b1);

    // Early release
    do_write(2'd1, 8'h80);
    @(negedge clk);
    do_write(2'd2, 8'h80);
    repeat (GDLY + 2) @(negedge clk);
    check("R9 gate never set", rdata, 8'h00);
    check("R9 clock running", func_clk_en, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule